// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands over several clock cycles using radix-2 Booth recoding. A single double-width product register does double duty. Its upper half collects partial sums, and its lower half first holds the multiplier operand. A multiplicand register sits beside it, and one extra bit to the right of the register remembers the bit most recently shifted out. On each iteration the block looks at the product's least significant bit and that extra bit. From the pair it chooses to add the multiplicand to the upper half, subtract it, or leave the upper half alone. It then shifts the whole register, with the extra bit, one place right arithmetically.

A caller pulses `start` with operands `a` (multiplicand) and `b` (multiplier) while the block is not busy. The block spends one cycle loading the operands and then one cycle per bit of operand width. When the last iteration is done it pulses `done` for one cycle, and the high and low halves of the product are then available on `hi` and `lo`. The result stays there until the next accepted start.

The controller has three states. `ST_IDLE` waits for work. `ST_RUN` performs one Booth iteration per clock. `ST_FINISH` presents the `done` pulse. The transitions are:
- load: `ST_IDLE` to `ST_RUN` on `start`;
- last-step: `ST_RUN` to `ST_FINISH` once iteration W-1 has executed;
- release: `ST_FINISH` to `ST_IDLE` when `start` is low;
- reload: `ST_FINISH` to `ST_RUN` on `start`.

Top module: `seq_booth_mul`

## Requirements
- R1: After reset `busy` and `done` are 0 and `hi` and `lo` are all zeros.
- R2: A `start` seen while `busy` is 0 loads `a` as the multiplicand and `b` into the low half, clears the high half and the extra bit, and `busy` reads 1 in the following cycle.
- R3: Each iteration decodes the pair (product bit 0, extra bit). Pair 1,0 subtracts the multiplicand from the upper half, pair 0,1 adds it, and pairs 0,0 and 1,1 leave the upper half unchanged. The extra bit is 0 before the first iteration.
- R4: After each add, subtract or no-op, the register and the extra bit shift right by one and take the sign of the true, not wrapped, intermediate sum. Products of the most negative operand are therefore correct.
- R5: Exactly W iterations run, one per clock. `done` first reads 1 W cycles after the cycle in which the operands were loaded (W=32 by default).
- R6: `done` is high for exactly one cycle, and `busy` and `done` are never high together.
- R7: When `done` is high, {`hi`,`lo`} equals the full 2W-bit signed product of `a` and `b`, with `hi` as the upper W bits.
- R8: A `start` that arrives while `busy` is 1 is ignored: the operation in progress ends with the result of the original operands.
- R9: While idle with no `start`, `hi` and `lo` hold their values even when `a` and `b` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a multiply with the present operands |
| a | input | W | Signed multiplicand |
| b | input | W | Signed multiplier |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse: result valid |
| hi | output | W | Upper half of the product |
| lo | output | W | Lower half of the product |

## Verification
A 6-bit instance is swept over every pair of signed operands. This covers runs of ones, isolated ones, all-ones multipliers and the most negative value in both roles. A design that wraps the upper half on overflow, or that shifts in a zero instead of the sign, gives wrong upper bits for products such as -32 times -32. A swapped add/subtract decode negates whole classes of results. At the default width, directed cases with the extreme operands check the same things, together with latency, a mid-run `start` and the holding of the result. An extra or missing iteration shows up as a result scaled by two and as a wrong cycle count. Accepting a second start while busy corrupts the first result.

// File: rtl/seq_booth_mul_pkg.sv
package seq_booth_mul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } mul_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import seq_booth_mul_pkg::*;
(
    input  logic      cur_bit,
    input  logic      right_bit,
    output booth_op_e op
);

    always_comb begin
        unique case ({cur_bit, right_bit})
            2'b10:   op = OP_SUB;   // start of a run of ones
            2'b01:   op = OP_ADD;   // end of a run of ones
            default: op = OP_NONE;  // inside a run of zeros or ones
        endcase
    end

endmodule

// File: rtl/booth_step.sv
module booth_step
    import seq_booth_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] hi_in,
    input  logic [W-1:0] lo_in,
    input  logic [W-1:0] mcand,
    input  booth_op_e    op,
    output logic [W-1:0] hi_out,
    output logic [W-1:0] lo_out,
    output logic         extra_out
);

    localparam int XW = W + 1;

    logic [XW-1:0] hi_x;
    logic [XW-1:0] mc_x;
    logic [XW-1:0] sum_x;

    // one guard bit keeps the true sign of the partial sum
    always_comb begin
        hi_x = {hi_in[W-1], hi_in};
        mc_x = {mcand[W-1], mcand};
        unique case (op)
            OP_ADD:  sum_x = hi_x + mc_x;
            OP_SUB:  sum_x = hi_x - mc_x;
            default: sum_x = hi_x;
        endcase
    end

    // arithmetic shift right of {sum, lo, extra} by one place
    always_comb begin
        hi_out    = sum_x[XW-1:1];
        lo_out    = {sum_x[0], lo_in[W-1:1]};
        extra_out = lo_in[0];
    end

endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
    import seq_booth_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mul_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        step    = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                busy = 1'b1;
                step = 1'b1;
                if (cnt_q == LAST) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                done = 1'b1;
                if (start) begin
                    load    = 1'b1;
                    state_d = ST_RUN;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R5: the finish state is only reached from the last iteration
    p_finish_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |-> ($past(state_q) == ST_RUN && $past(cnt_q) == LAST));

    // R6: done lasts one cycle unless a new run begins
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: an accepted start makes the block busy next cycle
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

// File: rtl/seq_booth_mul.sv
module seq_booth_mul
    import seq_booth_mul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);

    logic         load, step;
    logic [W-1:0] mcand_q;
    logic [W-1:0] hi_q, lo_q;
    logic         extra_q;
    logic [W-1:0] hi_n, lo_n;
    logic         extra_n;
    booth_op_e    op;

    mul_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    booth_recode u_recode (
        .cur_bit   (lo_q[0]),
        .right_bit (extra_q),
        .op        (op)
    );

    booth_step #(.W(W)) u_step (
        .hi_in     (hi_q),
        .lo_in     (lo_q),
        .mcand     (mcand_q),
        .op        (op),
        .hi_out    (hi_n),
        .lo_out    (lo_n),
        .extra_out (extra_n)
    );

    // multiplicand and shared product register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            extra_q <= 1'b0;
        end else if (load) begin
            mcand_q <= a;
            hi_q    <= '0;
            lo_q    <= b;
            extra_q <= 1'b0;
        end else if (step) begin
            hi_q    <= hi_n;
            lo_q    <= lo_n;
            extra_q <= extra_n;
        end
    end

    assign hi = hi_q;
    assign lo = lo_q;

    // R6: busy and done never overlap
    p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R8: the multiplicand is frozen while iterating
    p_mcand_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mcand_q));

    // R9: an idle block without start keeps its result
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(hi_q) && $stable(lo_q)));

    // R3: the extra bit starts from zero on a load
    p_extra_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (extra_q == 1'b0 && hi_q == '0));

endmodule

// File: tb/seq_booth_mul_tb.sv
module seq_booth_mul_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WS = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        start32 = 1'b0;
    logic [31:0] a32 = '0, b32 = '0;
    logic        busy32, done32;
    logic [31:0] hi32, lo32;

    logic          start_s = 1'b0;
    logic [WS-1:0] a_s = '0, b_s = '0;
    logic          busy_s, done_s;
    logic [WS-1:0] hi_s, lo_s;

    seq_booth_mul #(.W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start32), .a(a32), .b(b32),
        .busy(busy32), .done(done32), .hi(hi32), .lo(lo32)
    );

    seq_booth_mul #(.W(WS)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .start(start_s), .a(a_s), .b(b_s),
        .busy(busy_s), .done(done_s), .hi(hi_s), .lo(lo_s)
    );

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 190000) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            finish_up();
        end
    end

    // one multiply at the default width, with latency and pulse checks (R2 R5 R6 R7)
    task automatic run32(input logic [31:0] av, input logic [31:0] bv);
        longint sa, sb, prod;
        int cyc;
        sa = longint'($signed(av));
        sb = longint'($signed(bv));
        prod = sa * sb;
        @(negedge clk);
        a32 = av; b32 = bv; start32 = 1'b1;
        @(negedge clk);
        start32 = 1'b0;
        chk(busy32 == 1'b1, "R2 busy after start", 64'(busy32), 64'd1);
        cyc = 0;
        while (!done32 && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == 32, "R5 latency", 64'(cyc), 64'd32);
        chk({hi32, lo32} == 64'(prod), "R7 R4 product", {hi32, lo32}, 64'(prod));
        @(negedge clk);
        chk(done32 == 1'b0, "R6 done one cycle", 64'(done32), 64'd0);
    endtask

    // one multiply at the small width (R3 R4 R5 R7)
    task automatic run_small(input logic [WS-1:0] av, input logic [WS-1:0] bv);
        int sa, sb, prod;
        int cyc;
        sa = int'($signed(av));
        sb = int'($signed(bv));
        prod = sa * sb;
        @(negedge clk);
        a_s = av; b_s = bv; start_s = 1'b1;
        @(negedge clk);
        start_s = 1'b0;
        cyc = 0;
        while (!done_s && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == WS, "R5 small latency", 64'(cyc), 64'(WS));
        chk({hi_s, lo_s} == (2*WS)'(prod), "R3 R7 small product",
            64'({hi_s, lo_s}), 64'((2*WS)'(prod)));
    endtask

    initial begin
        #(CLK_PERIOD * 2 + 1);
        // R1 reset state
        chk(busy32 == 1'b0 && done32 == 1'b0, "R1 reset flags", {62'd0, busy32, done32}, 64'd0);
        chk({hi32, lo32} == 64'd0, "R1 reset product", {hi32, lo32}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy32 == 1'b0 && done32 == 1'b0, "R1 idle after reset", {62'd0, busy32, done32}, 64'd0);

        // R7 R4 directed corners at the default width
        run32(32'h0000_0002, 32'h0000_0007);
        run32(32'h0000_0002, 32'hFFFF_FFFD);
        run32(32'h8000_0000, 32'h8000_0000);
        run32(32'h8000_0000, 32'hFFFF_FFFF);
        run32(32'h7FFF_FFFF, 32'h7FFF_FFFF);
        run32(32'h7FFF_FFFF, 32'h8000_0000);
        run32(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run32(32'h0000_0000, 32'h1234_5678);
        run32(32'h1234_5678, 32'h0000_0000);
        run32(32'hDEAD_BEEF, 32'h5555_5555);
        run32(32'hAAAA_AAAA, 32'h0F0F_F0F0);

        // R8 start while busy is ignored
        begin
            longint p8;
            int cyc;
            p8 = longint'($signed(32'hFFFF_0003)) * longint'($signed(32'h0001_2345));
            @(negedge clk);
            a32 = 32'hFFFF_0003; b32 = 32'h0001_2345; start32 = 1'b1;
            @(negedge clk);
            start32 = 1'b0;
            repeat (5) @(negedge clk);
            a32 = 32'h7777_7777; b32 = 32'h8000_0001; start32 = 1'b1;
            @(negedge clk);
            start32 = 1'b0;
            cyc = 6;
            while (!done32 && cyc < 100) begin
                @(negedge clk);
                cyc++;
            end
            chk(cyc == 32, "R8 latency unaffected", 64'(cyc), 64'd32);
            chk({hi32, lo32} == 64'(p8), "R8 original result", {hi32, lo32}, 64'(p8));

            // R9 hold while idle with changing operands
            repeat (3) @(negedge clk);
            a32 = 32'h1111_1111; b32 = 32'h2222_2222;
            repeat (3) @(negedge clk);
            chk(busy32 == 1'b0, "R9 stays idle", 64'(busy32), 64'd0);
            chk({hi32, lo32} == 64'(p8), "R9 result held", {hi32, lo32}, 64'(p8));
        end

        // R3 R4 R7 exhaustive sweep of the small instance
        for (int i = 0; i < (1 << WS); i++) begin
            for (int j = 0; j < (1 << WS); j++) begin
                run_small(WS'(i), WS'(j));
            end
        end

        finish_up();
    end

endmodule